// File: doc/BRIEF.md
# Switchable Wormhole / Cut-Through Output Flit Buffer

This block sits between a router crossbar and one physical output link. Flits enter through a valid/ready handshake and leave through a second valid/ready handshake in the same format: a data word plus a head marker and a tail marker. A packet is a run of flits that starts with a head flit and ends with a tail flit. A flit carrying both markers is a complete one-flit packet.

A mode input selects the switching strategy. In wormhole mode each stored flit is offered to the link on the cycle after it is written, whether or not the rest of its packet has arrived. In cut-through mode the buffer holds a packet back until its tail flit has been stored, and then sends it one flit per accepted handshake. To ensure that a whole packet always fits, cut-through mode refuses a head flit unless the free space is at least the configured maximum packet length. A count of complete packets held in the buffer gates the output in cut-through mode. The mode is latched internally and can change only while the buffer is empty.

Top module: `switch_mode_obuf`

## Requirements
- R1: After reset the buffer is empty: `out_valid_o` is 0 and `in_ready_o` is 1.
- R2: In wormhole mode (`mode_i` = 0), a flit written at a clock edge is offered on the output from that edge on, even when its tail has not arrived.
- R3: In cut-through mode (`mode_i` = 1), `out_valid_o` stays 0 until the tail flit of the oldest packet has been written, and it rises at the edge that writes that tail.
- R4: Flits leave in the order they were accepted, with data, head bit and tail bit unchanged.
- R5: In cut-through mode, a head flit is refused (`in_ready_o` = 0) when free space is below MAX_PKT. Body and tail flits are accepted whenever the buffer is not full.
- R6: In wormhole mode, `in_ready_o` drops only when DEPTH flits are stored.
- R7: A flit with both head and tail set counts as a complete packet as soon as it is written.
- R8: A change of `mode_i` while the buffer holds flits has no effect. The new value takes effect once the buffer is empty.
- R9: While `out_valid_o` is 1 and `out_ready_i` is 0, the output flit and `out_valid_o` stay unchanged.
- R10: In cut-through mode, after one complete packet has drained, a second complete packet already stored is offered at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0 = wormhole, 1 = cut-through; sampled only while the buffer is empty |
| in_valid_i | input | 1 | Input flit valid |
| in_ready_o | output | 1 | Input flit accepted when high together with valid |
| in_data_i | input | DATA_W | Input flit payload |
| in_head_i | input | 1 | Input flit is the first of its packet |
| in_tail_i | input | 1 | Input flit is the last of its packet |
| out_valid_o | output | 1 | Output flit valid |
| out_ready_i | input | 1 | Link accepts the output flit |
| out_data_o | output | DATA_W | Output flit payload |
| out_head_o | output | 1 | Output flit head marker |
| out_tail_o | output | 1 | Output flit tail marker |

## Verification
The hardest state to reach is a cut-through head flit refused for lack of room while body and tail flits still go in. It needs one complete packet parked with the link stalled and a second packet part-stored, so that free space lies below MAX_PKT but above zero. The stimulus stalls the output and fills the buffer with exact flit counts. It then drains one flit at a time and confirms that the head flit stays refused until enough space is free. A second hard case is a mode change while the buffer holds a partial packet. The bench flips `mode_i` mid-packet and checks that the output still holds the packet back.

// File: rtl/obuf_pkg.sv
package obuf_pkg;

  typedef enum logic {
    SW_WORMHOLE = 1'b0,
    SW_CUT      = 1'b1
  } sw_mode_e;

endpackage

// File: rtl/obuf_store.sv
module obuf_store #(
  parameter int W     = 10,
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [W-1:0]     wr_flit_i,
  input  logic             rd_en_i,
  output logic [W-1:0]     rd_flit_o,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] free_o,
  output logic             full_o,
  output logic             empty_o
);

  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q, wr_ptr_n, rd_ptr_n;
  logic [CNT_W-1:0] count_q;

  // pointer wrap: free-running for power-of-two depth, compare otherwise
  generate
    if ((1 << PTR_W) == DEPTH) begin : g_pow2
      assign wr_ptr_n = wr_ptr_q + 1'b1;
      assign rd_ptr_n = rd_ptr_q + 1'b1;
    end else begin : g_wrap
      assign wr_ptr_n = (wr_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
      assign rd_ptr_n = (rd_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_ptr_q] <= wr_flit_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (wr_en_i) wr_ptr_q <= wr_ptr_n;
      if (rd_en_i) rd_ptr_q <= rd_ptr_n;
      case ({wr_en_i, rd_en_i})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  assign rd_flit_o = mem_q[rd_ptr_q];
  assign count_o   = count_q;
  assign free_o    = DEPTH_C - count_q;
  assign full_o    = (count_q == DEPTH_C);
  assign empty_o   = (count_q == '0);

  p_no_overflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> !full_o);

  p_no_underflow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |-> !empty_o);

endmodule

// File: rtl/obuf_pkt_track.sv
module obuf_pkt_track #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_tail_i,
  input  logic             rd_tail_i,
  input  logic [CNT_W-1:0] fill_i,
  output logic             have_pkt_o
);

  logic [CNT_W-1:0] pkt_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pkt_cnt_q <= '0;
    end else begin
      case ({wr_tail_i, rd_tail_i})
        2'b10:   pkt_cnt_q <= pkt_cnt_q + 1'b1;
        2'b01:   pkt_cnt_q <= pkt_cnt_q - 1'b1;
        default: pkt_cnt_q <= pkt_cnt_q;
      endcase
    end
  end

  assign have_pkt_o = (pkt_cnt_q != '0);

  // a stored tail implies at least that many stored flits
  p_pkt_le_fill_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_cnt_q <= fill_i);

  p_tail_read_counted_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_tail_i |-> pkt_cnt_q != '0);

endmodule

// File: rtl/obuf_mode_ctl.sv
module obuf_mode_ctl
  import obuf_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     mode_i,
  input  logic     empty_i,
  output sw_mode_e mode_o
);

  sw_mode_e mode_q;

  // empty buffer follows the pin directly; otherwise the latched mode holds
  assign mode_o = empty_i ? sw_mode_e'(mode_i) : mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= SW_WORMHOLE;
    else         mode_q <= mode_o;
  end

  p_mode_frozen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !empty_i |=> $stable(mode_q));

endmodule

// File: rtl/switch_mode_obuf.sv
module switch_mode_obuf
  import obuf_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int MAX_PKT = 4,
  parameter int DEPTH   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_head_i,
  input  logic              in_tail_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_head_o,
  output logic              out_tail_o
);

  localparam int FLIT_W = DATA_W + 2;
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] MAX_PKT_C = CNT_W'(MAX_PKT);

  logic              wr_en, rd_en, full, empty, have_pkt, cut_mode;
  logic [FLIT_W-1:0] wr_flit, rd_flit;
  logic [CNT_W-1:0]  fill, free;
  sw_mode_e          mode;

  assign wr_flit  = {in_head_i, in_tail_i, in_data_i};
  assign cut_mode = (mode == SW_CUT);

  obuf_mode_ctl u_mode (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_i  (mode_i),
    .empty_i (empty),
    .mode_o  (mode)
  );

  obuf_store #(.W(FLIT_W), .DEPTH(DEPTH)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_flit_i (wr_flit),
    .rd_en_i   (rd_en),
    .rd_flit_o (rd_flit),
    .count_o   (fill),
    .free_o    (free),
    .full_o    (full),
    .empty_o   (empty)
  );

  obuf_pkt_track #(.CNT_W(CNT_W)) u_track (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_tail_i  (wr_en && in_tail_i),
    .rd_tail_i  (rd_en && out_tail_o),
    .fill_i     (fill),
    .have_pkt_o (have_pkt)
  );

  // cut-through reserves room for a whole packet at its head
  assign in_ready_o  = !full && !(cut_mode && in_head_i && (free < MAX_PKT_C));
  assign out_valid_o = !empty && (!cut_mode || have_pkt);
  assign wr_en       = in_valid_i && in_ready_o;
  assign rd_en       = out_valid_o && out_ready_i;

  assign out_head_o = rd_flit[FLIT_W-1];
  assign out_tail_o = rd_flit[FLIT_W-2];
  assign out_data_o = rd_flit[DATA_W-1:0];

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(rd_flit));

  p_ct_room_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cut_mode && wr_en && in_head_i |-> free >= MAX_PKT_C);

endmodule

// File: tb/switch_mode_obuf_test.sv
`timescale 1ns/1ps
module switch_mode_obuf_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode = 1'b0;
  logic       in_valid = 1'b0, in_head = 1'b0, in_tail = 1'b0;
  logic [7:0] in_data = '0;
  logic       out_ready = 1'b0;
  logic       in_ready, out_valid, out_head, out_tail;
  logic [7:0] out_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  switch_mode_obuf #(.DATA_W(8), .MAX_PKT(4), .DEPTH(8)) uut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data),
    .in_head_i(in_head), .in_tail_i(in_tail),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data),
    .out_head_o(out_head), .out_tail_o(out_tail)
  );

  task automatic check_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d, input logic h, input logic t,
                      input logic exp_rdy, input string req);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_head = h; in_tail = t;
    #1 check_eq(req, int'(in_ready), int'(exp_rdy));
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic pop(input logic [7:0] d, input logic h, input logic t, input string req);
    @(negedge clk);
    out_ready = 1'b1;
    #1 check_eq(req, int'(out_valid), 1);
    check_eq(req, int'({out_head, out_tail, out_data}), int'({h, t, d}));
    @(posedge clk);
    #1 out_ready = 1'b0;
  endtask

  task automatic peek_valid(input logic exp, input string req);
    @(negedge clk);
    #1 check_eq(req, int'(out_valid), int'(exp));
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    @(negedge clk);
    #1 check_eq("R1 valid", int'(out_valid), 0);
    check_eq("R1 ready", int'(in_ready), 1);

    // R2 wormhole: head flit alone is offered
    mode = 1'b0;
    push(8'h10, 1'b1, 1'b0, 1'b1, "R2 accept");
    peek_valid(1'b1, "R2 forward before tail");
    // R6 fill to DEPTH
    for (int i = 1; i < 8; i++)
      push(8'(16 + i), 1'b0, (i == 7), 1'b1, "R6 ready below full");
    push(8'h18, 1'b0, 1'b0, 1'b0, "R6 ready low at full");
    // R9 hold while stalled
    for (int i = 0; i < 3; i++) begin
      peek_valid(1'b1, "R9 valid held");
      check_eq("R9 data held", int'(out_data), 'h10);
    end
    // R4 order
    for (int i = 0; i < 8; i++)
      pop(8'(16 + i), (i == 0), (i == 7), "R4 wormhole order");
    peek_valid(1'b0, "R4 drained");

    // R3 cut-through holds until tail
    mode = 1'b1;
    push(8'h20, 1'b1, 1'b0, 1'b1, "R3 head");
    peek_valid(1'b0, "R3 held after head");
    push(8'h21, 1'b0, 1'b0, 1'b1, "R3 body");
    push(8'h22, 1'b0, 1'b0, 1'b1, "R3 body");
    peek_valid(1'b0, "R3 held before tail");
    push(8'h23, 1'b0, 1'b1, 1'b1, "R3 tail");
    peek_valid(1'b1, "R3 valid after tail");
    for (int i = 0; i < 4; i++)
      pop(8'(32 + i), (i == 0), (i == 3), "R4 cut-through order");

    // R7 single-flit packet
    push(8'h30, 1'b1, 1'b1, 1'b1, "R7 accept");
    peek_valid(1'b1, "R7 complete on write");
    pop(8'h30, 1'b1, 1'b1, "R7 data");

    // R5 head refusal under low free space
    for (int i = 0; i < 4; i++)
      push(8'(64 + i), (i == 0), (i == 3), 1'b1, "R5 packet A");
    push(8'h48, 1'b1, 1'b0, 1'b1, "R5 head at free=MAX");
    push(8'h49, 1'b0, 1'b0, 1'b1, "R5 body below MAX");
    push(8'h4A, 1'b0, 1'b1, 1'b1, "R5 tail below MAX");
    push(8'h4F, 1'b1, 1'b1, 1'b0, "R5 head refused free=1");
    pop(8'h40, 1'b1, 1'b0, "R4 A0");
    push(8'h4F, 1'b1, 1'b1, 1'b0, "R5 head refused free=2");
    pop(8'h41, 1'b0, 1'b0, "R4 A1");
    pop(8'h42, 1'b0, 1'b0, "R4 A2");
    pop(8'h43, 1'b0, 1'b1, "R4 A3");
    peek_valid(1'b1, "R10 next packet offered");
    push(8'h4F, 1'b1, 1'b1, 1'b1, "R5 head accepted free=5");
    pop(8'h48, 1'b1, 1'b0, "R10 B0");
    pop(8'h49, 1'b0, 1'b0, "R4 B1");
    pop(8'h4A, 1'b0, 1'b1, "R4 B2");
    pop(8'h4F, 1'b1, 1'b1, "R4 C");

    // R8 mode change while non-empty is ignored
    push(8'h50, 1'b1, 1'b0, 1'b1, "R8 head");
    @(negedge clk);
    mode = 1'b0;
    #1 check_eq("R8 change ignored", int'(out_valid), 0);
    peek_valid(1'b0, "R8 still cut-through");
    push(8'h51, 1'b0, 1'b1, 1'b1, "R8 tail");
    pop(8'h50, 1'b1, 1'b0, "R8 pop head");
    pop(8'h51, 1'b0, 1'b1, "R8 pop tail");
    push(8'h60, 1'b1, 1'b0, 1'b1, "R8 wormhole head");
    peek_valid(1'b1, "R8 new mode applied when empty");
    push(8'h61, 1'b0, 1'b1, 1'b1, "R8 wormhole tail");
    pop(8'h60, 1'b1, 1'b0, "R8 pop");
    pop(8'h61, 1'b0, 1'b1, "R8 pop");
    peek_valid(1'b0, "R1 empty at end");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule